// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides, for a processor core, whether a given event moves the core out of normal execution into a background debug state, or is handled the ordinary way. Whether debug entry is allowed at all is set once, when reset is released: the core samples an active-low breakpoint pin through a synchronizer at that moment and keeps the result until the next reset.

While running, the block watches four event sources. The first is a falling edge on the synchronized breakpoint pin. The second is a decoded opcode strobe carrying either the reserved background opcode or a software breakpoint opcode. The third is a pair of bus faults with no good bus cycle between them. For each accepted event it emits a single-cycle result made of a 2-bit code and an 8-bit vector offset. The same source gives a different result depending on the latched enable. The block issues no acknowledge bus cycle of any kind; it only reports the decision.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When the breakpoint pin has been low for at least two clock cycles before the clock edge at which rst_n is first seen high, debug entry is enabled. A pin that is low for only one cycle before that edge leaves it disabled.
- R2: A high pin at reset release disables debug entry. The flag is sampled again at every release and keeps its value between releases.
- R3: While rst_n is low, res_valid stays 0 and all event inputs are ignored.
- R4: A falling edge of the synchronized pin gives code 0 (enter background, vector 0x00) when enabled. When disabled it gives code 1 (exception) with vector 0x0C.
- R5: Opcode 0x4AFA gives code 0 (vector 0x00) when enabled. When disabled it gives code 1 with vector 0x10.
- R6: A bus fault while a first fault is pending is a double fault. It gives code 0 when enabled and code 2 (halt, vector 0x00) when disabled.
- R7: A single bus fault produces no result. A bus_ok strobe clears a pending fault, so a later fault counts as a first fault again.
- R8: Opcodes 0x4848 to 0x484F give code 3 (illegal/substituted, vector 0x10) in both enable states and never code 0.
- R9: Any other opcode produces no result.
- R10: At most one result is produced per cycle. The order of precedence is double fault, then pin edge, then opcode, and the losing events are dropped.
- R11: A pin held low across reset release produces no breakpoint result, including in the first cycle after release.
- R12: The result for an opcode or fault appears one clock after the cycle in which the event is presented, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; its release latches the enable |
| bkpt_n | input | 1 | Asynchronous breakpoint pin, active low |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 16 | Opcode presented with op_valid |
| bus_fault | input | 1 | Bus cycle ended with a fault |
| bus_ok | input | 1 | Bus cycle ended successfully |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 enter background, 1 exception, 2 halt, 3 illegal/substituted |
| res_vector | output | 8 | Vector offset for the result |

## Verification
The bench targets the boundary of the enable sample. A pin low for exactly two cycles must enable, and a pin low for only one must not; a design with an extra or missing sync stage gets one of these wrong. A pin held low through release would, without the first-cycle mask and edge detection, produce a breakpoint result that nobody asked for. Mixing faults with bus_ok catches a tracker that never clears or that counts single faults. The enable and disable passes catch swapped result tables. Same-cycle collisions of a fault with an opcode, and of a pin edge with an opcode, expose a wrong priority or a design that emits two results.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    RES_BG   = 2'd0,
    RES_EXC  = 2'd1,
    RES_HALT = 2'd2,
    RES_ILL  = 2'd3
  } res_code_e;
endpackage

// File: rtl/dbg_pin_sync.sv
// Synchronizes the breakpoint pin and turns its falling edge into an event.
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  input  logic live,
  input  logic first_op,
  output logic pin_sync_n,
  output logic pin_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain[0] <= pin_n;
    end else begin : g_rest
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  end

  assign pin_sync_n = chain[STAGES-1];

  // Outside operation the previous level reads as released, so a pin held
  // low across release looks like an edge in the first cycle; it is masked.
  always_ff @(posedge clk) begin
    if (!live) prev_q <= 1'b1;
    else       prev_q <= pin_sync_n;
  end

  assign pin_evt = live & ~first_op & prev_q & ~pin_sync_n;
endmodule

// File: rtl/dbg_enable_latch.sv
// Tracks reset release and latches the debug enable at that edge.
module dbg_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_n,
  output logic dbg_en,
  output logic live,
  output logic first_op
);
  logic rst_q;
  logic live_q;

  always_ff @(posedge clk) begin
    rst_q  <= rst_n;
    live_q <= rst_n & rst_q;
    if (!rst_n)     dbg_en <= 1'b0;
    else if (!rst_q) dbg_en <= ~pin_sync_n;
  end

  assign live     = rst_n & rst_q;
  assign first_op = live & ~live_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && $past(rst_q)) |-> $stable(dbg_en)); // R2
endmodule

// File: rtl/dbg_fault_track.sv
// Detects two bus faults with no successful cycle between them.
module dbg_fault_track (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic bus_fault,
  input  logic bus_ok,
  output logic dbf_evt
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (live) begin
      if (bus_fault)   pend_q <= ~pend_q;
      else if (bus_ok) pend_q <= 1'b0;
    end
  end

  assign dbf_evt = live & bus_fault & pend_q;
endmodule

// File: rtl/dbg_event_resolve.sv
// Chooses the winning source and maps it to a result code and vector.
module dbg_event_resolve
  import dbg_entry_pkg::*;
#(
  parameter int              OPC_W    = 16,
  parameter int              VEC_W    = 8,
  parameter logic [OPC_W-1:0] BG_OPC   = 16'h4AFA,
  parameter logic [OPC_W-1:0] SWBP_BASE = 16'h4848,
  parameter logic [OPC_W-1:0] SWBP_MASK = 16'hFFF8,
  parameter logic [VEC_W-1:0] VEC_BKPT = 8'h0C,
  parameter logic [VEC_W-1:0] VEC_ILL  = 8'h10
) (
  input  logic             dbg_en,
  input  logic             dbf_evt,
  input  logic             pin_evt,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output logic             hit,
  output res_code_e        code,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    hit  = 1'b0;
    code = RES_BG;
    vec  = '0;
    if (dbf_evt) begin
      hit  = 1'b1;
      code = dbg_en ? RES_BG : RES_HALT;
    end else if (pin_evt) begin
      hit = 1'b1;
      if (!dbg_en) begin
        code = RES_EXC;
        vec  = VEC_BKPT;
      end
    end else if (op_valid) begin
      if (op_code == BG_OPC) begin
        hit = 1'b1;
        if (!dbg_en) begin
          code = RES_EXC;
          vec  = VEC_ILL;
        end
      end else if ((op_code & SWBP_MASK) == SWBP_BASE) begin
        hit  = 1'b1;
        code = RES_ILL;
        vec  = VEC_ILL;
      end
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               OPC_W       = 16,
  parameter int               VEC_W       = 8,
  parameter logic [OPC_W-1:0] BG_OPC      = 16'h4AFA,
  parameter logic [OPC_W-1:0] SWBP_BASE   = 16'h4848,
  parameter logic [OPC_W-1:0] SWBP_MASK   = 16'hFFF8,
  parameter logic [VEC_W-1:0] VEC_BKPT    = 8'h0C,
  parameter logic [VEC_W-1:0] VEC_ILL     = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkpt_n,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             bus_fault,
  input  logic             bus_ok,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic [VEC_W-1:0] res_vector
);
  logic             pin_sync_n, pin_evt;
  logic             dbg_en, live, first_op;
  logic             dbf_evt;
  logic             hit;
  res_code_e        code;
  logic [VEC_W-1:0] vec;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pin_n(bkpt_n), .live(live), .first_op(first_op),
    .pin_sync_n(pin_sync_n), .pin_evt(pin_evt)
  );

  dbg_enable_latch u_en (
    .clk(clk), .rst_n(rst_n), .pin_sync_n(pin_sync_n),
    .dbg_en(dbg_en), .live(live), .first_op(first_op)
  );

  dbg_fault_track u_flt (
    .clk(clk), .rst_n(rst_n), .live(live),
    .bus_fault(bus_fault), .bus_ok(bus_ok), .dbf_evt(dbf_evt)
  );

  dbg_event_resolve #(
    .OPC_W(OPC_W), .VEC_W(VEC_W), .BG_OPC(BG_OPC), .SWBP_BASE(SWBP_BASE),
    .SWBP_MASK(SWBP_MASK), .VEC_BKPT(VEC_BKPT), .VEC_ILL(VEC_ILL)
  ) u_res (
    .dbg_en(dbg_en), .dbf_evt(dbf_evt), .pin_evt(pin_evt),
    .op_valid(op_valid & live), .op_code(op_code),
    .hit(hit), .code(code), .vec(vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_code   <= 2'd0;
      res_vector <= '0;
    end else begin
      res_valid  <= hit;
      res_code   <= code;
      res_vector <= vec;
    end
  end

  AST_BG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_BG) |-> dbg_en); // R1
  AST_EXC_ONLY_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_EXC) |-> !dbg_en); // R4
  AST_HALT_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_HALT) |-> (!dbg_en && $past(bus_fault))); // R6
  AST_ILL_FROM_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_ILL) |-> (res_vector == VEC_ILL && $past(op_valid))); // R8
endmodule

// File: tb/sim_dbg_entry_ctrl.sv
module sim_dbg_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkpt_n = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] op_code = 16'h0000;
  logic        bus_fault = 1'b0;
  logic        bus_ok = 1'b0;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [7:0]  res_vector;

  always #10 clk = ~clk;

  dbg_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bkpt_n(bkpt_n), .op_valid(op_valid),
    .op_code(op_code), .bus_fault(bus_fault), .bus_ok(bus_ok),
    .res_valid(res_valid), .res_code(res_code), .res_vector(res_vector)
  );

  typedef struct {
    logic [1:0] code;
    logic [7:0] vec;
    string      req;
  } exp_t;

  exp_t  sb[$];
  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R3";
  bit    done = 1'b0;

  // Monitor: every result is popped against the scoreboard.
  always @(negedge clk) begin
    if (res_valid === 1'b1) begin
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected result code=%0d vec=%h, expected none",
                 cur_req, res_code, res_vector);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_code !== e.code || res_vector !== e.vec) begin
          n_fail++;
          $display("FAIL %s: got code=%0d vec=%h, expected code=%0d vec=%h",
                   e.req, res_code, res_vector, e.code, e.vec);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_res(input logic [1:0] c, input logic [7:0] v, input string r);
    exp_t e;
    e.code = c; e.vec = v; e.req = r;
    sb.push_back(e);
  endtask

  task automatic idle_check(input string r);
    cur_req = r;
    cyc(5);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected results missing, expected 0", r, sb.size());
      sb.delete();
    end
  endtask

  task automatic send_op(input logic [15:0] op);
    op_valid = 1'b1; op_code = op;
    cyc(1);
    op_valid = 1'b0;
  endtask

  task automatic fault1();
    bus_fault = 1'b1;
    cyc(1);
    bus_fault = 1'b0;
  endtask

  task automatic pin_pulse();
    bkpt_n = 1'b0;
    cyc(4);
    bkpt_n = 1'b1;
    cyc(3);
  endtask

  // Pin is driven to 'pin' for 'low_cyc' cycles before release.
  task automatic do_reset(input logic pin, input int low_cyc);
    rst_n = 1'b0; bkpt_n = 1'b1;
    cyc(4);
    bkpt_n = pin;
    cyc(low_cyc);
    rst_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R3: reset state and ignored inputs during reset
    cyc(3);
    n_tests++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R3: res_valid=%b, expected 0", res_valid);
    end
    cur_req = "R3";
    send_op(16'h4AFA);
    fault1(); fault1();
    send_op(16'h4848);
    idle_check("R3");

    // Enabled pass; pin stays low across release (R11)
    cur_req = "R11";
    do_reset(1'b0, 4);
    cyc(3);
    idle_check("R11");
    bkpt_n = 1'b1;
    idle_check("R11");

    expect_res(2'd0, 8'h00, "R5"); send_op(16'h4AFA); idle_check("R5");
    // R12 latency: result one clock later, one cycle wide
    expect_res(2'd0, 8'h00, "R12");
    op_valid = 1'b1; op_code = 16'h4AFA;
    cyc(1);
    op_valid = 1'b0;
    n_tests++;
    if (res_valid !== 1'b1) begin
      n_fail++; $display("FAIL R12: res_valid=%b one cycle after op, expected 1", res_valid);
    end
    cyc(1);
    n_tests++;
    if (res_valid !== 1'b0) begin
      n_fail++; $display("FAIL R12: res_valid=%b two cycles after op, expected 0", res_valid);
    end
    expect_res(2'd0, 8'h00, "R4"); cur_req = "R4"; pin_pulse(); idle_check("R4");
    cur_req = "R6"; fault1(); expect_res(2'd0, 8'h00, "R6"); fault1(); idle_check("R6");
    cur_req = "R7"; fault1(); idle_check("R7");
    bus_ok = 1'b1; cyc(1); bus_ok = 1'b0;
    fault1(); idle_check("R7");
    bus_ok = 1'b1; cyc(1); bus_ok = 1'b0;
    expect_res(2'd3, 8'h10, "R8"); send_op(16'h4848);
    expect_res(2'd3, 8'h10, "R8"); send_op(16'h484F);
    idle_check("R8");
    cur_req = "R9";
    send_op(16'h4AFB); send_op(16'h4840); send_op(16'h4E71); send_op(16'h4850);
    idle_check("R9");

    // Disabled pass (R2)
    cur_req = "R2";
    do_reset(1'b1, 4);
    expect_res(2'd1, 8'h10, "R2"); send_op(16'h4AFA); idle_check("R2");
    expect_res(2'd1, 8'h10, "R5"); send_op(16'h4AFA);
    expect_res(2'd1, 8'h0C, "R4"); cur_req = "R4"; pin_pulse(); idle_check("R4");
    cur_req = "R6"; fault1(); expect_res(2'd2, 8'h00, "R6"); fault1(); idle_check("R6");
    expect_res(2'd3, 8'h10, "R8"); send_op(16'h484A); idle_check("R8");
    // R10: double fault beats opcode in the same cycle
    cur_req = "R10";
    fault1();
    expect_res(2'd2, 8'h00, "R10");
    bus_fault = 1'b1; op_valid = 1'b1; op_code = 16'h4AFA;
    cyc(1);
    bus_fault = 1'b0; op_valid = 1'b0;
    idle_check("R10");
    // R10: pin edge beats opcode in the same cycle
    expect_res(2'd1, 8'h0C, "R10");
    bkpt_n = 1'b0;
    cyc(2);
    send_op(16'h4848);
    cyc(2);
    bkpt_n = 1'b1;
    idle_check("R10");

    // R1: pin low one cycle only before release -> disabled
    cur_req = "R1";
    do_reset(1'b0, 1);
    cyc(2);
    bkpt_n = 1'b1;
    idle_check("R1");
    expect_res(2'd1, 8'h10, "R1"); send_op(16'h4AFA); idle_check("R1");
    // R1: exactly two cycles low -> enabled, re-sampled (R2)
    do_reset(1'b0, 2);
    cyc(2);
    bkpt_n = 1'b1;
    idle_check("R1");
    expect_res(2'd0, 8'h00, "R1"); send_op(16'h4AFA); idle_check("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule